// File: doc/BRIEF.md
# Clock Settle Gate and Even Divider

This block keeps the core clock switched off after a reset, or after a wake from power-down, until the selected oscillator has had time to become stable. The settling wait depends on the clock source. Crystal sources need a count of oscillator cycles and then a wait measured in time. The RC source needs only the timed wait. The watchdog and external sources need a short cycle count. Timed waits are measured by counting a 1 µs tick input.

Once the clock has settled, the block divides the oscillator clock by an even ratio taken from an 8-bit divide input. This produces a core clock enable, and a peripheral clock enable at half the core rate. The ratio can be changed at any time. A new ratio is taken only at the end of the divider period that is running, so the core clock never has a short or missing pulse. A low-power flag is cleared on every reset and is written through a strobe.

The settling controller is a four-state machine:
- `ST_LATCH` captures the source code.
  - It goes to `ST_USWAIT` for the RC source.
  - It goes to `ST_CYCLES` for all other sources.
- `ST_CYCLES` counts oscillator cycles.
  - It goes to `ST_USWAIT` for a crystal source.
  - It goes to `ST_RUN` for the other sources.
- `ST_USWAIT` counts µs ticks, then goes to `ST_RUN`.
- `ST_RUN` returns to `ST_LATCH` on a wake request.

Reset places the machine in `ST_LATCH`.

Top module: `clk_settle_div`

## Requirements
- R1: While rst_n is low, core_ready, cclk_en, pclk_en and lowpwr are all 0.
- R2: With src_sel = 00 (crystal), core_ready rises 1 + 1024 clocks after the latch cycle, and then after a further 64 us_tick pulses (60 plus MARGIN_US = 4). Ticks count only from the clock after the cycle count ends.
- R3: With src_sel = 01 (RC oscillator), core_ready rises after 204 us_tick pulses (200 plus MARGIN_US), counted from the clock after the latch cycle.
- R4: With src_sel = 10 (watchdog) or 11 (external), core_ready rises 32 clocks after the latch cycle. After reset release this is on the 33rd rising edge.
- R5: src_sel is sampled only in the latch cycle. A change during the rest of the settling sequence does not alter its length.
- R6: wake_req sampled high while running drops core_ready on the next clock and starts a new settling sequence. The latch cycle follows, and src_sel is sampled in it. wake_req during settling has no effect.
- R7: cclk_en and pclk_en stay low whenever core_ready is low. core_ready and cclk enabling start together at the end of the settling count.
- R8: With div_val = 0, cclk_en is high on every running clock. With div_val = N (1..255), cclk_en pulses once every 2·N clocks.
- R9: A div_val change takes effect only after the next cclk_en pulse. The interval in progress finishes at the old ratio.
- R10: pclk_en is high on every second cclk_en pulse, starting with the second pulse after core_ready rises. It is never high without cclk_en.
- R11: lowpwr loads lp_wdata on a clock where lp_wr is high, holds its value otherwise, and is 0 after every reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (OSCCLK) |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-clock pulse every microsecond |
| src_sel | input | 2 | Clock source: 00 crystal, 01 RC, 10 watchdog, 11 external |
| wake_req | input | 1 | Restart the settling sequence (power-down wake) |
| div_val | input | 8 | Divide setting N; ratio 2·N, 0 = pass-through |
| lp_wr | input | 1 | Write strobe for the low-power flag |
| lp_wdata | input | 1 | Value written to the low-power flag |
| cclk_en | output | 1 | Core clock enable |
| pclk_en | output | 1 | Peripheral clock enable (half of core rate) |
| core_ready | output | 1 | Settling finished, core clock running |
| lowpwr | output | 1 | Low-power select flag |

## Verification
The bench measures the exact settling edge for each source class, including the point where the crystal sequence switches from cycles to ticks. A design that counted ticks during the cycle phase, or that was off by one in either counter, would raise core_ready on the wrong edge.

The bench changes the source select and pulses wake_req in the middle of a sequence. A design that resampled the source, or restarted the sequence, would lengthen or shorten the wait.

The bench rewrites the divide ratio in the middle of a period, including a drop from 255 to 1. A design that loaded the ratio at once would cut the 510-clock interval short. The bench also checks that pclk_en falls on the even-numbered core pulses and never appears during settling.

// File: rtl/cgd_pkg.sv
`timescale 1ns/1ps
package cgd_pkg;
    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_RC   = 2'b01,
        SRC_WDOG = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_LATCH,
        ST_CYCLES,
        ST_USWAIT,
        ST_RUN
    } settle_e;
endpackage

// File: rtl/cgd_settle_fsm.sv
`timescale 1ns/1ps
module cgd_settle_fsm
    import cgd_pkg::*;
#(
    parameter int XTAL_CYC   = 1024,
    parameter int DIRECT_CYC = 32,
    parameter int XTAL_US    = 60,
    parameter int RC_US      = 200,
    parameter int MARGIN_US  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [1:0] src_sel,
    input  logic       wake_req,
    output logic       run
);
    localparam int CYC_MAX = (XTAL_CYC > DIRECT_CYC) ? XTAL_CYC : DIRECT_CYC;
    localparam int CW      = $clog2(CYC_MAX + 1);
    localparam int US_X    = XTAL_US + MARGIN_US;
    localparam int US_R    = RC_US + MARGIN_US;
    localparam int US_MAX  = (US_X > US_R) ? US_X : US_R;
    localparam int UW      = $clog2(US_MAX + 1);

    settle_e        st, nxt;
    src_e           src_q;
    logic [CW-1:0]  cyc_cnt, cyc_lim;
    logic [UW-1:0]  us_cnt, us_lim;

    // limits follow the source captured in the latch cycle
    always_comb begin
        cyc_lim = (src_q == SRC_XTAL) ? CW'(XTAL_CYC - 1) : CW'(DIRECT_CYC - 1);
        us_lim  = (src_q == SRC_XTAL) ? UW'(US_X - 1)     : UW'(US_R - 1);
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_LATCH:  nxt = (src_e'(src_sel) == SRC_RC) ? ST_USWAIT : ST_CYCLES;
            ST_CYCLES: if (cyc_cnt == cyc_lim)
                           nxt = (src_q == SRC_XTAL) ? ST_USWAIT : ST_RUN;
            ST_USWAIT: if (us_tick && us_cnt == us_lim) nxt = ST_RUN;
            ST_RUN:    if (wake_req) nxt = ST_LATCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LATCH;
        else        st <= nxt;
    end

    // counters and captured source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= SRC_XTAL;
            cyc_cnt <= '0;
            us_cnt  <= '0;
        end else begin
            if (st == ST_LATCH) src_q <= src_e'(src_sel);
            if (st == ST_CYCLES && nxt == ST_CYCLES) cyc_cnt <= cyc_cnt + CW'(1);
            else                                     cyc_cnt <= '0;
            if (st == ST_USWAIT) begin
                if (us_tick) us_cnt <= (nxt == ST_USWAIT) ? us_cnt + UW'(1) : '0;
            end else begin
                us_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        run = (st == ST_RUN);
    end

    // R5
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LATCH) |=> $stable(src_q));

    // R3
    tick_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_USWAIT && !us_tick) |=> (st != ST_RUN));

    // R6
    wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wake_req) |=> (st == ST_LATCH));
endmodule

// File: rtl/cgd_even_div.sv
`timescale 1ns/1ps
module cgd_even_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             cclk_en,
    output logic             pclk_en
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] cur;
    logic [CNT_W-1:0] cnt, last;
    logic             ph, term;

    always_comb begin
        last = (cur == '0) ? '0 : ({cur, 1'b0} - CNT_W'(1));
        term = run && (cnt == last);
    end

    // ratio reloads only at terminal count or while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            cur <= '0;
            ph  <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            cur <= div_val;
            ph  <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            cur <= div_val;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        cclk_en = term;
        pclk_en = term && ph;
    end

    // R9
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !term) |=> (!run || $stable(cur)));

    // R10
    pclk_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_en |-> cclk_en);
endmodule

// File: rtl/cgd_lp_flag.sv
`timescale 1ns/1ps
module cgd_lp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  flag <= 1'b0;
        else if (wr) flag <= wdata;
    end

    // R11
    lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(flag));
endmodule

// File: rtl/clk_settle_div.sv
`timescale 1ns/1ps
module clk_settle_div #(
    parameter int XTAL_CYC   = 1024,
    parameter int DIRECT_CYC = 32,
    parameter int XTAL_US    = 60,
    parameter int RC_US      = 200,
    parameter int MARGIN_US  = 4,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic [1:0]       src_sel,
    input  logic             wake_req,
    input  logic [DIV_W-1:0] div_val,
    input  logic             lp_wr,
    input  logic             lp_wdata,
    output logic             cclk_en,
    output logic             pclk_en,
    output logic             core_ready,
    output logic             lowpwr
);
    logic run;

    cgd_settle_fsm #(
        .XTAL_CYC(XTAL_CYC), .DIRECT_CYC(DIRECT_CYC),
        .XTAL_US(XTAL_US), .RC_US(RC_US), .MARGIN_US(MARGIN_US)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .src_sel(src_sel), .wake_req(wake_req), .run(run)
    );

    cgd_even_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val),
        .cclk_en(cclk_en), .pclk_en(pclk_en)
    );

    cgd_lp_flag u_lp (
        .clk(clk), .rst_n(rst_n), .wr(lp_wr), .wdata(lp_wdata), .flag(lowpwr)
    );

    assign core_ready = run;

    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ready |-> (!cclk_en && !pclk_en));
endmodule

// File: tb/clk_settle_div_bench.sv
`timescale 1ns/1ps
module clk_settle_div_bench;
    localparam int XTAL_CYC = 1024;
    localparam int DIR_CYC  = 32;
    localparam int XTAL_TK  = 64;
    localparam int RC_TK    = 204;
    localparam int TICK_DIV = 10;

    logic       clk = 1'b0;
    logic       rst_n, us_tick, wake_req, lp_wr, lp_wdata;
    logic [1:0] src_sel;
    logic [7:0] div_val;
    logic       cclk_en, pclk_en, core_ready, lowpwr;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    clk_settle_div u_clk_settle_div (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .src_sel(src_sel),
        .wake_req(wake_req), .div_val(div_val), .lp_wr(lp_wr), .lp_wdata(lp_wdata),
        .cclk_en(cclk_en), .pclk_en(pclk_en), .core_ready(core_ready), .lowpwr(lowpwr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // microsecond tick source, changed just after rising edges
    initial begin
        us_tick = 1'b0;
        forever begin
            for (int k = 0; k < TICK_DIV; k++) begin
                @(posedge clk); #2;
                us_tick = (k == TICK_DIV - 1);
            end
        end
    end

    // scoreboard monitor: predicts each cclk interval from div_val at the previous pulse
    initial begin
        int   gap, pidx, e;
        bit   have;
        logic [7:0] v_last;
        gap = 0; pidx = 0; have = 0; v_last = '0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1 || core_ready !== 1'b1) begin
                if (cclk_en === 1'b1 || pclk_en === 1'b1)
                    chk(0, "R7 enable while not ready", 1, 0);
                exp_q.delete();
                have = 0; pidx = 0; gap = 0;
            end else begin
                gap++;
                if (cclk_en) begin
                    pidx++;
                    chk(pclk_en == (pidx % 2 == 0), "R10 pclk phase", int'(pclk_en), int'(pidx % 2 == 0));
                    if (have) begin
                        e = exp_q.pop_front();
                        chk(gap == e, (div_val != v_last) ? "R9 interval" : "R8 interval", gap, e);
                    end
                    exp_q.push_back((div_val == 0) ? 1 : 2 * int'(div_val));
                    v_last = div_val;
                    have = 1;
                    gap = 0;
                end else if (pclk_en) begin
                    chk(0, "R10 pclk without cclk", 1, 0);
                end
            end
        end
    end

    // settle sequence measurement; base = edge index of the latch cycle
    task automatic settle(input int base, input int cyc, input int ticks, input bit do_wake,
                          input int chg_at, input logic [1:0] chg_val, input int wk_at,
                          input string tag);
        int e, tc, done;
        bit early;
        e = 0; tc = 0; early = 0;
        done = (ticks == 0) ? base + cyc : -1;
        if (do_wake) begin
            @(posedge clk); #2;
            wake_req = 1'b1;
        end
        forever begin
            @(negedge clk);
            if (e >= 1) wake_req = (e == wk_at);
            if (e == chg_at) src_sel = chg_val;
            if (done >= 0 && e == done) begin
                chk(core_ready == 1'b1, {tag, " ready edge"}, int'(core_ready), 1);
                chk(!early, "R7 low during settle", int'(early), 0);
                break;
            end
            if ((e >= 1 || !do_wake) && (core_ready || cclk_en)) early = 1;
            if (ticks > 0 && e + 1 > base + cyc && us_tick) begin
                tc++;
                if (tc == ticks) done = e + 1;
            end
            e++;
            if (e > 5000) begin
                chk(0, {tag, " never ready"}, e, done);
                break;
            end
        end
    endtask

    task automatic set_div(input int v, input int pulses);
        @(posedge clk); #2;
        div_val = 8'(v);
        for (int p = 0; p < pulses; p++) begin
            @(negedge clk);
            while (!cclk_en) @(negedge clk);
        end
    endtask

    task automatic lp_write(input logic v);
        @(posedge clk); #2;
        lp_wr = 1'b1; lp_wdata = v;
        @(posedge clk); #2;
        lp_wr = 1'b0; lp_wdata = ~v;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "timeout (run hung)", 0, 1);
        summary();
    end

    initial begin
        rst_n = 1'b0; src_sel = 2'b10; div_val = 8'd0; wake_req = 1'b0;
        lp_wr = 1'b0; lp_wdata = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(core_ready == 0, "R1 core_ready", int'(core_ready), 0);
        chk(cclk_en == 0 && pclk_en == 0, "R1 enables", int'(cclk_en), 0);
        chk(lowpwr == 0, "R1 lowpwr", int'(lowpwr), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        // R4 watchdog source from reset
        settle(1, DIR_CYC, 0, 0, -1, 2'b00, -1, "R4 watchdog");

        // R8 divider ratios, R9 mid-period changes, R10 peripheral phase
        set_div(0, 8);
        set_div(1, 6);
        set_div(3, 6);
        set_div(255, 2);
        repeat (100) @(posedge clk);
        set_div(1, 5);
        set_div(2, 5);

        // R11 low-power flag
        lp_write(1'b1);
        @(negedge clk); chk(lowpwr == 1, "R11 set", int'(lowpwr), 1);
        repeat (5) @(posedge clk);
        @(negedge clk); chk(lowpwr == 1, "R11 hold", int'(lowpwr), 1);
        lp_write(1'b0);
        @(negedge clk); chk(lowpwr == 0, "R11 clear", int'(lowpwr), 0);
        lp_write(1'b1);

        // R2 crystal via wake (R6)
        src_sel = 2'b00;
        settle(2, XTAL_CYC, XTAL_TK, 1, -1, 2'b00, -1, "R2 crystal");
        set_div(1, 3);
        // R3 RC via wake
        src_sel = 2'b01;
        settle(2, 0, RC_TK, 1, -1, 2'b00, -1, "R3 rc");
        set_div(0, 3);
        // R5 select change mid-sequence is ignored
        src_sel = 2'b11;
        settle(2, DIR_CYC, 0, 1, 5, 2'b01, -1, "R5 held select");
        // R6 wake during settling is ignored
        src_sel = 2'b10;
        settle(2, DIR_CYC, 0, 1, -1, 2'b00, 10, "R6 wake ignored");
        set_div(2, 4);

        // R1 / R11: reset clears the low-power flag
        @(negedge clk); chk(lowpwr == 1, "R11 before reset", int'(lowpwr), 1);
        @(posedge clk); #2; rst_n = 1'b0;
        @(negedge clk);
        chk(lowpwr == 0, "R11 reset clears", int'(lowpwr), 0);
        chk(core_ready == 0 && cclk_en == 0, "R1 reset again", int'(core_ready), 0);
        @(posedge clk); #2; rst_n = 1'b1;
        settle(1, DIR_CYC, 0, 0, -1, 2'b00, -1, "R4 after reset");
        set_div(1, 4);
        summary();
    end
endmodule